// File: doc/BRIEF.md
# Disk Sector Format Sequencer

This block produces the serial bit sequence for writing one or more disk sectors. A write starts with a pulse on `start_i` that carries a total word count and a format mode. For each sector the block first opens a read gate. It lets a fixed run of preamble bit slots go by, then hunts for a single one bit as the sync mark. It shifts in three 16-bit header words from the read stream and waits through a gap of zero bits. At the end of the gap it compares the recovered header with the expected header on `hdr_exp_i`.

Only when the header matches does the block close the read gate and open the write gate. It then emits a data preamble, 256 data words, a 32-bit check word from an external code generator, and a postamble. The data words are 16 or 18 bits wide. A valid/ready handshake feeds them, one word each time a word boundary is reached. After each sector the block starts the next header phase if words remain. When the count has run out it returns to idle with a one-cycle done pulse.

A sector whose header does not match is skipped: the write gate stays low, a sticky header error is raised and no words are used. A word missing at a load point aborts the write with a sticky underrun error. All sequencing advances on a bit-clock enable, one bit slot per pulse.

Top module: `dsf_sequencer`

## Requirements
- R1: A `start_i` pulse while idle with a nonzero `word_cnt_i` latches the count and `wide_i`, clears both error flags, raises `busy_o` and enters the header preamble with `rd_gate_o` high. A start with a zero count, or any start while busy, changes nothing.
- R2: The header preamble lasts 128 bit slots, during which `rd_bit_i` is ignored. The block then waits, over any number of slots, for a slot with `rd_bit_i` = 1, which is the sync mark.
- R3: After the sync slot, 48 header bits are taken from `rd_bit_i` most significant first, so the first bit lands in `hdr_exp_i[47]`. A gap of 64 bit slots follows, and the compare is made at the last gap slot.
- R4: On a header match, `rd_gate_o` falls and `wr_gate_o` rises at that same bit-clock edge. `mstat_o` carries the read gate in bit 15 and the write gate in bit 14, with all other bits 0. The two gates are never high together.
- R5: On a header mismatch, `wr_gate_o` stays low, `hdr_err_o` is set and stays set until the next accepted start, and the header preamble restarts without taking any data word.
- R6: The data preamble occupies 256 bit slots on `wr_bit_o`: 255 zeros, then a one.
- R7: The data field holds 256 words sent most significant bit first. With `wide_i` = 0 at start, each word is the low 16 bits of `wd_data_i`. With `wide_i` = 1, each word is all 18 bits.
- R8: `wd_ready_o` is high only in a cycle with `bit_en_i` high, at the last preamble slot or at the last bit slot of a word that is not the sector's final word, and only while words remain. A word is taken when `wd_valid_i` is also high.
- R9: Once the word count is exhausted inside a sector, the remaining data words of that sector are sent as zeros and no ready is raised.
- R10: After the data, 32 check bits from `chk_word_i` (sampled at the edge that enters the check field) are sent most significant first, followed by 16 postamble zero bits.
- R11: After the postamble, the next sector begins at the header preamble if words remain. Otherwise the block goes idle and pulses `done_o` for one cycle.
- R12: If `wd_ready_o` is high while `wd_valid_i` is low, the block aborts at that edge: both gates drop, `busy_o` falls, `urun_err_o` is set (sticky until the next accepted start), and no done pulse follows.
- R13: State and outputs change only at edges where `bit_en_i` is high (apart from start). `wr_bit_o` is 0 whenever `wr_gate_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a multi-sector write |
| word_cnt_i | input | 16 | Total number of data words to write |
| wide_i | input | 1 | Word format: 0 = 16-bit, 1 = 18-bit |
| hdr_exp_i | input | 48 | Expected header, first word in the top 16 bits |
| bit_en_i | input | 1 | Bit-clock enable, one bit slot per pulse |
| rd_bit_i | input | 1 | Serial read data during the header phase |
| wd_data_i | input | 18 | Data word to write |
| wd_valid_i | input | 1 | Data word available |
| wd_ready_o | output | 1 | Data word taken at this edge |
| chk_word_i | input | 32 | Check word from the external code generator |
| rd_gate_o | output | 1 | Read gate, high through the header phase |
| wr_gate_o | output | 1 | Write gate, high through the data portion |
| wr_bit_o | output | 1 | Serial write data |
| mstat_o | output | 16 | Status: bit 15 read gate, bit 14 write gate |
| busy_o | output | 1 | A write is in progress |
| done_o | output | 1 | One-cycle pulse at normal completion |
| hdr_err_o | output | 1 | Sticky header mismatch flag |
| urun_err_o | output | 1 | Sticky data underrun flag |

## Verification
A slot counter that is off by one shows at the ports within a single sector. The gate edges move, the preamble's one bit lands in the wrong slot, or `wd_ready_o` is raised one bit slot early or late. Because the reference compares gates, serial data and ready on every clock, such a fault is seen at the first bit slot where it differs. A wrong word pointer or count shows as wrong data bits, or as a missing zero fill, in the first affected word. A stale compare result shows as a write gate that opens on a bad header, in the very slot after the gap.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    // Sector phases, header part first, then the write part.
    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_HPRE  = 4'd1,
        ST_HSYNC = 4'd2,
        ST_HDR   = 4'd3,
        ST_GAP   = 4'd4,
        ST_DPRE  = 4'd5,
        ST_DATA  = 4'd6,
        ST_CHK   = 4'd7,
        ST_POST  = 4'd8
    } dsf_state_e;

endpackage

// File: rtl/dsf_hdr_capture.sv
module dsf_hdr_capture #(
    parameter int HDR_BITS = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_i,
    input  logic                bit_i,
    input  logic [HDR_BITS-1:0] exp_i,
    output logic                match_o
);

    typedef struct packed {
        logic [HDR_BITS-1:0] sh;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (shift_i) begin
            c_d.sh = {c_q.sh[HDR_BITS-2:0], bit_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign match_o = (c_q.sh == exp_i);

endmodule

// File: rtl/dsf_bit_shifter.sv
module dsf_bit_shifter #(
    parameter int SER_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SER_W-1:0] load_val_i,
    input  logic             shift_i,
    output logic             msb_o
);

    typedef struct packed {
        logic [SER_W-1:0] sr;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.sr = load_val_i;
        end else if (shift_i) begin
            s_d.sr = {s_q.sr[SER_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign msb_o = s_q.sr[SER_W-1];

endmodule

// File: rtl/dsf_word_align.sv
module dsf_word_align #(
    parameter int DW_WIDE   = 18,
    parameter int DW_NARROW = 16,
    parameter int SER_W     = 32
) (
    input  logic                 wide_i,
    input  logic [DW_WIDE-1:0]   data_i,
    output logic [SER_W-1:0]     word_o
);

    localparam int PAD_W = SER_W - DW_WIDE;
    localparam int PAD_N = SER_W - DW_NARROW;

    logic [SER_W-1:0] al_wide;
    logic [SER_W-1:0] al_narrow;

    // Left-justify so the first bit to send sits in the top position.
    assign al_wide   = {data_i, {PAD_W{1'b0}}};
    assign al_narrow = {data_i[DW_NARROW-1:0], {PAD_N{1'b0}}};
    assign word_o    = wide_i ? al_wide : al_narrow;

endmodule

// File: rtl/dsf_seq_ctrl.sv
module dsf_seq_ctrl
    import dsf_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int HPRE_BITS = 128,
    parameter int HDR_BITS  = 48,
    parameter int GAP_BITS  = 64,
    parameter int DPRE_BITS = 256,
    parameter int SEC_WORDS = 256,
    parameter int DW_WIDE   = 18,
    parameter int DW_NARROW = 16,
    parameter int SER_W     = 32,
    parameter int POST_BITS = 16,
    parameter int SLOT_W    = 8,
    parameter int SWD_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] word_cnt_i,
    input  logic             wide_i,
    input  logic             bit_en_i,
    input  logic             rd_bit_i,
    input  logic             hdr_match_i,
    input  logic             wd_valid_i,
    input  logic [SER_W-1:0] word_al_i,
    input  logic [SER_W-1:0] chk_i,
    output logic             wd_ready_o,
    output logic             hdr_shift_o,
    output logic             ser_load_o,
    output logic [SER_W-1:0] ser_val_o,
    output logic             wide_o,
    output logic             rd_gate_o,
    output logic             wr_gate_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             hdr_err_o,
    output logic             urun_err_o
);

    localparam logic [SLOT_W-1:0] HPRE_LAST = SLOT_W'(HPRE_BITS - 1);
    localparam logic [SLOT_W-1:0] HDR_LAST  = SLOT_W'(HDR_BITS - 1);
    localparam logic [SLOT_W-1:0] GAP_LAST  = SLOT_W'(GAP_BITS - 1);
    localparam logic [SLOT_W-1:0] DPRE_LAST = SLOT_W'(DPRE_BITS - 1);
    localparam logic [SLOT_W-1:0] DPRE_PEN  = SLOT_W'(DPRE_BITS - 2);
    localparam logic [SLOT_W-1:0] CHK_LAST  = SLOT_W'(SER_W - 1);
    localparam logic [SLOT_W-1:0] POST_LAST = SLOT_W'(POST_BITS - 1);
    localparam logic [SLOT_W-1:0] WIDE_LAST = SLOT_W'(DW_WIDE - 1);
    localparam logic [SLOT_W-1:0] NARW_LAST = SLOT_W'(DW_NARROW - 1);
    localparam logic [SWD_W-1:0]  SWD_LAST  = SWD_W'(SEC_WORDS - 1);
    localparam logic [SER_W-1:0]  SYNC_ONE  = {1'b1, {(SER_W-1){1'b0}}};

    typedef struct packed {
        dsf_state_e        st;
        logic [SLOT_W-1:0] slot;
        logic [SWD_W-1:0]  swd;
        logic [CNT_W-1:0]  wcnt;
        logic              wide;
        logic              done;
        logic              hdr_err;
        logic              urun;
    } ctrl_t;

    ctrl_t             r_d, r_q;
    logic              want_word;
    logic [SLOT_W-1:0] word_last;

    assign word_last = r_q.wide ? WIDE_LAST : NARW_LAST;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        want_word  = 1'b0;
        ser_load_o = 1'b0;
        ser_val_o  = '0;

        case (r_q.st)
            ST_IDLE: begin
                if (start_i && (word_cnt_i != '0)) begin
                    r_d.st      = ST_HPRE;
                    r_d.slot    = '0;
                    r_d.wcnt    = word_cnt_i;
                    r_d.wide    = wide_i;
                    r_d.hdr_err = 1'b0;
                    r_d.urun    = 1'b0;
                end
            end
            ST_HPRE: begin
                if (bit_en_i) begin
                    if (r_q.slot == HPRE_LAST) begin
                        r_d.st   = ST_HSYNC;
                        r_d.slot = '0;
                    end else begin
                        r_d.slot = r_q.slot + 1'b1;
                    end
                end
            end
            ST_HSYNC: begin
                if (bit_en_i && rd_bit_i) begin
                    r_d.st   = ST_HDR;
                    r_d.slot = '0;
                end
            end
            ST_HDR: begin
                if (bit_en_i) begin
                    if (r_q.slot == HDR_LAST) begin
                        r_d.st   = ST_GAP;
                        r_d.slot = '0;
                    end else begin
                        r_d.slot = r_q.slot + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (bit_en_i) begin
                    r_d.slot = '0;
                    if (r_q.slot != GAP_LAST) begin
                        r_d.slot = r_q.slot + 1'b1;
                    end else if (hdr_match_i) begin
                        r_d.st     = ST_DPRE;
                        ser_load_o = 1'b1;
                        ser_val_o  = '0;
                    end else begin
                        r_d.st      = ST_HPRE;
                        r_d.hdr_err = 1'b1;
                    end
                end
            end
            ST_DPRE: begin
                if (bit_en_i) begin
                    if (r_q.slot == DPRE_LAST) begin
                        r_d.st    = ST_DATA;
                        r_d.slot  = '0;
                        r_d.swd   = '0;
                        want_word = 1'b1;
                    end else begin
                        r_d.slot = r_q.slot + 1'b1;
                        if (r_q.slot == DPRE_PEN) begin
                            ser_load_o = 1'b1;
                            ser_val_o  = SYNC_ONE;
                        end
                    end
                end
            end
            ST_DATA: begin
                if (bit_en_i) begin
                    if (r_q.slot != word_last) begin
                        r_d.slot = r_q.slot + 1'b1;
                    end else if (r_q.swd == SWD_LAST) begin
                        r_d.st     = ST_CHK;
                        r_d.slot   = '0;
                        ser_load_o = 1'b1;
                        ser_val_o  = chk_i;
                    end else begin
                        r_d.slot  = '0;
                        r_d.swd   = r_q.swd + 1'b1;
                        want_word = 1'b1;
                    end
                end
            end
            ST_CHK: begin
                if (bit_en_i) begin
                    if (r_q.slot == CHK_LAST) begin
                        r_d.st     = ST_POST;
                        r_d.slot   = '0;
                        ser_load_o = 1'b1;
                        ser_val_o  = '0;
                    end else begin
                        r_d.slot = r_q.slot + 1'b1;
                    end
                end
            end
            ST_POST: begin
                if (bit_en_i) begin
                    if (r_q.slot == POST_LAST) begin
                        r_d.slot = '0;
                        if (r_q.wcnt != '0) begin
                            r_d.st = ST_HPRE;
                        end else begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end
                    end else begin
                        r_d.slot = r_q.slot + 1'b1;
                    end
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        // Word boundary: take a word, fill with zeros, or abort on underrun.
        if (want_word) begin
            ser_load_o = 1'b1;
            ser_val_o  = '0;
            if (r_q.wcnt != '0) begin
                if (wd_valid_i) begin
                    ser_val_o = word_al_i;
                    r_d.wcnt  = r_q.wcnt - 1'b1;
                end else begin
                    r_d.st   = ST_IDLE;
                    r_d.slot = '0;
                    r_d.urun = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wd_ready_o  = want_word && (r_q.wcnt != '0);
    assign hdr_shift_o = bit_en_i && (r_q.st == ST_HDR);
    assign wide_o      = r_q.wide;
    assign rd_gate_o   = (r_q.st == ST_HPRE) || (r_q.st == ST_HSYNC) ||
                         (r_q.st == ST_HDR)  || (r_q.st == ST_GAP);
    assign wr_gate_o   = (r_q.st == ST_DPRE) || (r_q.st == ST_DATA) ||
                         (r_q.st == ST_CHK)  || (r_q.st == ST_POST);
    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign hdr_err_o   = r_q.hdr_err;
    assign urun_err_o  = r_q.urun;

endmodule

// File: rtl/dsf_sequencer.sv
module dsf_sequencer #(
    parameter int CNT_W      = 16,
    parameter int HPRE_BITS  = 128,
    parameter int HDR_WORDS  = 3,
    parameter int HDR_WORD_W = 16,
    parameter int GAP_BITS   = 64,
    parameter int DPRE_BITS  = 256,
    parameter int SEC_WORDS  = 256,
    parameter int DW_WIDE    = 18,
    parameter int DW_NARROW  = 16,
    parameter int CHK_BITS   = 32,
    parameter int POST_BITS  = 16,
    parameter int STAT_W     = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [CNT_W-1:0]               word_cnt_i,
    input  logic                           wide_i,
    input  logic [HDR_WORDS*HDR_WORD_W-1:0] hdr_exp_i,
    input  logic                           bit_en_i,
    input  logic                           rd_bit_i,
    input  logic [DW_WIDE-1:0]             wd_data_i,
    input  logic                           wd_valid_i,
    output logic                           wd_ready_o,
    input  logic [CHK_BITS-1:0]            chk_word_i,
    output logic                           rd_gate_o,
    output logic                           wr_gate_o,
    output logic                           wr_bit_o,
    output logic [STAT_W-1:0]              mstat_o,
    output logic                           busy_o,
    output logic                           done_o,
    output logic                           hdr_err_o,
    output logic                           urun_err_o
);

    localparam int HDR_BITS = HDR_WORDS * HDR_WORD_W;
    localparam int SER_W    = CHK_BITS;
    localparam int M1       = (HPRE_BITS > GAP_BITS) ? HPRE_BITS : GAP_BITS;
    localparam int M2       = (DPRE_BITS > HDR_BITS) ? DPRE_BITS : HDR_BITS;
    localparam int M3       = (SER_W > POST_BITS) ? SER_W : POST_BITS;
    localparam int M12      = (M1 > M2) ? M1 : M2;
    localparam int MAXB     = (M12 > M3) ? M12 : M3;
    localparam int SLOT_W   = $clog2(MAXB);
    localparam int SWD_W    = $clog2(SEC_WORDS);

    logic             hdr_shift;
    logic             hdr_match;
    logic             ser_load;
    logic [SER_W-1:0] ser_val;
    logic             ser_msb;
    logic             wide_q;
    logic [SER_W-1:0] word_al;

    dsf_hdr_capture #(
        .HDR_BITS (HDR_BITS)
    ) u_hdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (hdr_shift),
        .bit_i   (rd_bit_i),
        .exp_i   (hdr_exp_i),
        .match_o (hdr_match)
    );

    dsf_word_align #(
        .DW_WIDE   (DW_WIDE),
        .DW_NARROW (DW_NARROW),
        .SER_W     (SER_W)
    ) u_align (
        .wide_i (wide_q),
        .data_i (wd_data_i),
        .word_o (word_al)
    );

    dsf_bit_shifter #(
        .SER_W (SER_W)
    ) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ser_load),
        .load_val_i (ser_val),
        .shift_i    (bit_en_i),
        .msb_o      (ser_msb)
    );

    dsf_seq_ctrl #(
        .CNT_W     (CNT_W),
        .HPRE_BITS (HPRE_BITS),
        .HDR_BITS  (HDR_BITS),
        .GAP_BITS  (GAP_BITS),
        .DPRE_BITS (DPRE_BITS),
        .SEC_WORDS (SEC_WORDS),
        .DW_WIDE   (DW_WIDE),
        .DW_NARROW (DW_NARROW),
        .SER_W     (SER_W),
        .POST_BITS (POST_BITS),
        .SLOT_W    (SLOT_W),
        .SWD_W     (SWD_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .word_cnt_i  (word_cnt_i),
        .wide_i      (wide_i),
        .bit_en_i    (bit_en_i),
        .rd_bit_i    (rd_bit_i),
        .hdr_match_i (hdr_match),
        .wd_valid_i  (wd_valid_i),
        .word_al_i   (word_al),
        .chk_i       (chk_word_i),
        .wd_ready_o  (wd_ready_o),
        .hdr_shift_o (hdr_shift),
        .ser_load_o  (ser_load),
        .ser_val_o   (ser_val),
        .wide_o      (wide_q),
        .rd_gate_o   (rd_gate_o),
        .wr_gate_o   (wr_gate_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .hdr_err_o   (hdr_err_o),
        .urun_err_o  (urun_err_o)
    );

    assign wr_bit_o = wr_gate_o & ser_msb;
    assign mstat_o  = {rd_gate_o, wr_gate_o, {(STAT_W-2){1'b0}}};

endmodule

// File: rtl/dsf_sequencer_chk.sv
module dsf_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en_i,
    input logic wd_valid_i,
    input logic wd_ready_o,
    input logic rd_gate_o,
    input logic wr_gate_o,
    input logic wr_bit_o,
    input logic busy_o,
    input logic done_o,
    input logic hdr_err_o,
    input logic urun_err_o
);

    AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_gate_o && wr_gate_o)); // R4

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_gate_o) |-> $past(rd_gate_o)); // R4

    AST_MISMATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_err_o) |-> !wr_gate_o); // R5

    AST_READY_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        wd_ready_o |-> bit_en_i); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R11

    AST_UNDERRUN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_ready_o && !wd_valid_i) |=> (urun_err_o && !busy_o && !wr_gate_o && !done_o)); // R12

    AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !bit_en_i) |=> $stable({rd_gate_o, wr_gate_o, wr_bit_o})); // R13

    AST_WRBIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gate_o |-> !wr_bit_o); // R13

endmodule

bind dsf_sequencer dsf_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en_i   (bit_en_i),
    .wd_valid_i (wd_valid_i),
    .wd_ready_o (wd_ready_o),
    .rd_gate_o  (rd_gate_o),
    .wr_gate_o  (wr_gate_o),
    .wr_bit_o   (wr_bit_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .hdr_err_o  (hdr_err_o),
    .urun_err_o (urun_err_o)
);

// File: tb/tb_dsf_sequencer.sv
module tb_dsf_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] word_cnt_i = '0;
    logic        wide_i = 1'b0;
    logic [47:0] hdr_exp_i = '0;
    logic        bit_en_i = 1'b0;
    logic        rd_bit_i = 1'b0;
    logic [17:0] wd_data_i = '0;
    logic        wd_valid_i = 1'b0;
    logic        wd_ready_o;
    logic [31:0] chk_word_i = '0;
    logic        rd_gate_o, wr_gate_o, wr_bit_o;
    logic [15:0] mstat_o;
    logic        busy_o, done_o, hdr_err_o, urun_err_o;

    always #5 clk = ~clk;

    dsf_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_cnt_i(word_cnt_i),
        .wide_i(wide_i), .hdr_exp_i(hdr_exp_i), .bit_en_i(bit_en_i),
        .rd_bit_i(rd_bit_i), .wd_data_i(wd_data_i), .wd_valid_i(wd_valid_i),
        .wd_ready_o(wd_ready_o), .chk_word_i(chk_word_i), .rd_gate_o(rd_gate_o),
        .wr_gate_o(wr_gate_o), .wr_bit_o(wr_bit_o), .mstat_o(mstat_o),
        .busy_o(busy_o), .done_o(done_o), .hdr_err_o(hdr_err_o),
        .urun_err_o(urun_err_o)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Reference: one entry per bit slot {rd_gate, wr_gate, wr_bit, ready}.
    logic [3:0]  exp_q[$];
    logic        rd_q[$];
    string       tag_q[$];
    logic [17:0] words[$];
    logic [17:0] src_q[$];
    bit          expect_urun;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input string tag, input logic rg, input logic wg,
                        input logic wb, input logic rdy, input logic rd);
        exp_q.push_back({rg, wg, wb, rdy});
        rd_q.push_back(rd);
        tag_q.push_back(tag);
    endtask

    task automatic build(input logic [47:0] feed, input bit match, input int hunt,
                         input bit noise, input bit wide, input logic [31:0] chkw,
                         inout int avail, inout int ptr, output bit stop);
        int          wl;
        logic [17:0] v;
        bit          need;
        stop = 0;
        wl = wide ? 18 : 16;
        for (int i = 0; i < 128; i++) push("R2 preamble", 1, 0, 0, 0, noise && (i % 37 == 5));
        for (int i = 0; i < hunt; i++) push("R2 hunt", 1, 0, 0, 0, 0);
        push("R2 sync", 1, 0, 0, 0, 1);
        for (int i = 0; i < 48; i++) push("R3 header", 1, 0, 0, 0, feed[47-i]);
        for (int i = 0; i < 64; i++) push("R3 gap", 1, 0, 0, 0, 0);
        if (!match) return;
        for (int i = 0; i < 255; i++) push("R6 data preamble", 0, 1, 0, 0, 0);
        need = (avail > 0);
        push("R6 preamble one", 0, 1, 1, need, 0);
        if (need && ptr >= words.size()) begin stop = 1; return; end
        for (int w = 0; w < 256; w++) begin
            bit have;
            have = (avail > 0);
            v = have ? words[ptr] : 18'd0;
            if (have) begin ptr++; avail--; end
            for (int b = 0; b < wl; b++) begin
                need = (b == wl - 1) && (w < 255) && (avail > 0);
                push(have ? "R7 data" : "R9 zero fill", 0, 1, v[wl-1-b], need, 0);
                if (need && ptr >= words.size()) begin stop = 1; return; end
            end
        end
        for (int i = 0; i < 32; i++) push("R10 check", 0, 1, chkw[31-i], 0, 0);
        for (int i = 0; i < 16; i++) push("R10 postamble", 0, 1, 0, 0, 0);
    endtask

    task automatic drive_src();
        wd_valid_i = (src_q.size() != 0);
        wd_data_i  = (src_q.size() != 0) ? src_q[0] : 18'd0;
    endtask

    task automatic cmp_slot(input int i, input bit en);
        logic [3:0] e;
        e = exp_q[i];
        chk($sformatf("%s%s slot %0d", en ? "" : "R13 hold ", tag_q[i], i),
            {29'd0, rd_gate_o, wr_gate_o, wr_bit_o},
            {29'd0, e[3], e[2], e[1]});
        chk(en ? "R8 ready at bit edge" : "R8 ready without enable",
            {31'd0, wd_ready_o}, {31'd0, en ? e[0] : 1'b0});
        chk("R4 status bits", {16'd0, mstat_o}, {16'd0, e[3], e[2], 14'd0});
    endtask

    task automatic run(input int cnt, input bit wide, input logic [31:0] chkw,
                       input logic [47:0] hdr, input int nsrc, input bit bad_first,
                       input int restart_at);
        int avail, ptr, s;
        bit stop, took;
        exp_q.delete(); rd_q.delete(); tag_q.delete(); words.delete(); src_q.delete();
        for (int k = 0; k < nsrc; k++) begin
            logic [17:0] v;
            v = 18'((k * 40503 + cnt * 977) ^ (k << 7) ^ 18'h2A5A5);
            words.push_back(v);
            src_q.push_back(v);
        end
        avail = cnt; ptr = 0; s = 0; stop = 0;
        if (bad_first) build(hdr ^ 48'h1, 0, 2, 0, wide, chkw, avail, ptr, stop);
        do begin
            build(hdr, 1, s % 3, s % 2 == 0, wide, chkw, avail, ptr, stop);
            s++;
        end while (!stop && avail > 0);
        expect_urun = stop;

        @(negedge clk);
        hdr_exp_i = hdr; chk_word_i = chkw; word_cnt_i = 16'(cnt); wide_i = wide;
        start_i = 1; bit_en_i = 0; drive_src();
        took = 0;
        for (int i = 0; i < exp_q.size(); i++) begin
            @(negedge clk);
            if (took) begin void'(src_q.pop_front()); took = 0; end
            bit_en_i = 0; rd_bit_i = rd_q[i];
            start_i = (i == restart_at);          // R1: start while busy is ignored
            word_cnt_i = (i == restart_at) ? 16'd3 : word_cnt_i;
            wide_i = (i == restart_at) ? ~wide : wide;
            drive_src();
            #1;
            if (i == 0) chk("R1 busy after start", {31'd0, busy_o}, 32'd1);
            cmp_slot(i, 0);
            @(negedge clk);
            start_i = 0; bit_en_i = 1;
            #1;
            cmp_slot(i, 1);
            took = exp_q[i][0] && wd_valid_i;
        end
        @(negedge clk);
        if (took) void'(src_q.pop_front());
        bit_en_i = 0; rd_bit_i = 0; drive_src();
        #1;
        chk("R11 busy low at end", {31'd0, busy_o}, 32'd0);
        chk("R11 gates low at end", {30'd0, rd_gate_o, wr_gate_o}, 32'd0);
        if (expect_urun) begin
            chk("R12 underrun flag", {31'd0, urun_err_o}, 32'd1);
            chk("R12 no done on abort", {31'd0, done_o}, 32'd0);
        end else begin
            chk("R11 done pulse", {31'd0, done_o}, 32'd1);
            chk("R12 no underrun", {31'd0, urun_err_o}, 32'd0);
        end
        chk("R5 header error flag", {31'd0, hdr_err_o}, {31'd0, bad_first});
        @(negedge clk);
        #1;
        chk("R11 done one cycle", {31'd0, done_o}, 32'd0);
    endtask

    initial begin : watchdog
        #1900000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R1 reset busy", {31'd0, busy_o}, 32'd0);
        chk("R4 reset gates", {30'd0, rd_gate_o, wr_gate_o}, 32'd0);
        chk("R4 reset status", {16'd0, mstat_o}, 32'd0);
        chk("R8 reset ready", {31'd0, wd_ready_o}, 32'd0);
        chk("R5 reset flags", {30'd0, hdr_err_o, urun_err_o}, 32'd0);

        // R1: zero count start is ignored, R13: no output while idle
        @(negedge clk);
        word_cnt_i = 0; start_i = 1; bit_en_i = 1; rd_bit_i = 1;
        @(negedge clk);
        start_i = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 zero count ignored", {31'd0, busy_o}, 32'd0);
        chk("R13 idle write bit", {30'd0, wr_gate_o, wr_bit_o}, 32'd0);
        bit_en_i = 0; rd_bit_i = 0;

        // Narrow words, two sectors, second one zero-filled (R7, R9, R11)
        run(300, 0, 32'hA5C3_0F1E, 48'h1234_5678_9ABC, 300, 0, -1);
        // Wide words, first header bad (R5), start while busy (R1)
        run(256, 1, 32'h8123_4567, 48'hFEDC_0001_8000, 256, 1, 300);
        // Wide words, source runs dry (R12)
        run(10, 1, 32'h0F0F_F0F0, 48'hC0DE_5EC7_0042, 5, 0, -1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule